// File: doc/BRIEF.md
# Instruction Fetch Stage with Branch Redirect

This block is the front stage of a simple in-order pipeline. A program counter selects a word in a small internal instruction store. Each cycle that the stage advances, the word at the current PC and the value PC+1 are captured into the fetch-to-decode pipeline register, together with a valid flag. Instructions are word addressed, so the sequential successor of any PC is PC+1, and that value wraps at the size of the store.

The stage takes three control inputs from later in the pipe. The first is a stall that freezes the PC and the pipeline register together. The second is a redirect strobe, which comes from the execute stage. The third is the redirect target. On a redirect, the PC is loaded from the target. The slot that would have carried the wrong-path instruction becomes a bubble, with its valid flag cleared. Fetch then resumes at the target on the next advancing cycle.

The instruction store has a simple write port, which is used to fill it with a program before or during operation. Decode, execute and branch prediction are outside this block.

Top module: `fetch_unit`

## Requirements
- R1: While `rst_n` is low, `ifid_valid`, `ifid_instr` and `ifid_pc1` are 0 and the PC is set to RESET_PC (default 0). The first advancing cycle after reset therefore presents the word at address 0 with `ifid_pc1` = 1.
- R2: In each cycle where `stall` = 0 and `redirect` = 0, the PC advances by one, modulo 2^ADDR_W. After address 2^ADDR_W-1, the next fetch comes from address 0.
- R3: On an advancing cycle, the pipeline register loads three values at the clock edge: the store word at the current PC into `ifid_instr`, the value PC+1 into `ifid_pc1`, and 1 into `ifid_valid`. They are visible one cycle after the PC was presented.
- R4: When `redirect` = 1 at a clock edge, the PC takes `redirect_target`. The next advancing cycle then delivers the store word at the target, with `ifid_pc1` = target+1.
- R5: When `stall` = 1 and `redirect` = 0, the PC and all three pipeline register outputs keep their values. This holds for a bubble too.
- R6: A redirect takes priority over a stall in the same cycle. The PC still loads the target and the slot is still squashed.
- R7: A squashed slot has `ifid_valid` = 0. With CLEAR_ON_SQUASH = 1 (the default), `ifid_instr` and `ifid_pc1` are also 0 in that slot.
- R8: When `load_we` = 1 at a clock edge, the store word at `load_addr` takes `load_data`. A later fetch from that address returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze PC and pipeline register |
| redirect | input | 1 | Load PC from target and squash the fetch slot |
| redirect_target | input | ADDR_W | Word address to resume fetch from |
| load_we | input | 1 | Write strobe for the instruction store |
| load_addr | input | ADDR_W | Store write address |
| load_data | input | DATA_W | Store write data |
| ifid_instr | output | DATA_W | Fetched instruction word |
| ifid_pc1 | output | ADDR_W | Address following the fetched instruction |
| ifid_valid | output | 1 | Slot holds a real instruction (0 = bubble) |

## Verification
The assertions check several rules on every cycle:
- the PC moves by one when the stage advances, holds under a stall, and lands on the target after a redirect;
- the pipeline register captures the fetched word and its successor address, or stays frozen;
- every redirect leaves a cleared bubble, even when it coincides with a stall.

Only the bench scenarios can show that the words delivered match the program that was loaded. They also show that the PC wraps correctly at the top of the store, that a write made while running is seen by a later fetch, and that long random mixes of stalls and back-to-back redirects keep the instruction order a reference model expects.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

   // Next-PC selection, decoded once and shared by PC and IF/ID registers
   typedef enum logic [1:0] {
      PC_SEQ  = 2'd0,
      PC_HOLD = 2'd1,
      PC_JUMP = 2'd2
   } pc_sel_e;

   // Redirect outranks stall (R6)
   function automatic pc_sel_e pick_sel(input logic stall_i, input logic redir_i);
      if (redir_i) return PC_JUMP;
      if (stall_i) return PC_HOLD;
      return PC_SEQ;
   endfunction

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
   import fetch_pkg::*;
(
   input  logic    stall,
   input  logic    redirect,
   output pc_sel_e sel
);

   always_comb begin
      sel = pick_sel(stall, redirect);
   end

endmodule

// File: rtl/fetch_pc.sv
module fetch_pc
   import fetch_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int RESET_PC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pc_sel_e           sel,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc_q,
   output logic [ADDR_W-1:0] pc_inc
);

   localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);
   localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);

   // Word addressing: successor is PC+1, wrapping at 2^ADDR_W
   assign pc_inc = pc_q + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= PC_INIT;
      end else begin
         case (sel)
            PC_JUMP: pc_q <= target;
            PC_SEQ:  pc_q <= pc_inc;
            default: pc_q <= pc_q;
         endcase
      end
   end

   a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == PC_SEQ) |=> (pc_q == $past(pc_q) + ONE));

   a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == PC_JUMP) |=> (pc_q == $past(target)));

   a_r5_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == PC_HOLD) |=> $stable(pc_q));

endmodule

// File: rtl/fetch_rom.sv
module fetch_rom #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Synchronous write; read data is registered downstream in IF/ID
   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/fetch_ifid.sv
module fetch_ifid
   import fetch_pkg::*;
#(
   parameter int ADDR_W          = 6,
   parameter int DATA_W          = 32,
   parameter bit CLEAR_ON_SQUASH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pc_sel_e           sel,
   input  logic [DATA_W-1:0] fetch_word,
   input  logic [ADDR_W-1:0] fetch_pc1,
   output logic [DATA_W-1:0] instr_q,
   output logic [ADDR_W-1:0] pc1_q,
   output logic              valid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else begin
         case (sel)
            PC_JUMP: valid_q <= 1'b0;
            PC_SEQ:  valid_q <= 1'b1;
            default: valid_q <= valid_q;
         endcase
      end
   end

   generate
      if (CLEAR_ON_SQUASH) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               instr_q <= '0;
               pc1_q   <= '0;
            end else begin
               case (sel)
                  PC_JUMP: begin
                     instr_q <= '0;
                     pc1_q   <= '0;
                  end
                  PC_SEQ: begin
                     instr_q <= fetch_word;
                     pc1_q   <= fetch_pc1;
                  end
                  default: begin
                     instr_q <= instr_q;
                     pc1_q   <= pc1_q;
                  end
               endcase
            end
         end

         a_r7_bubble_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == PC_JUMP) |=> (instr_q == '0 && pc1_q == '0));
      end else begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               instr_q <= '0;
               pc1_q   <= '0;
            end else if (sel == PC_SEQ) begin
               instr_q <= fetch_word;
               pc1_q   <= fetch_pc1;
            end
         end
      end
   endgenerate

   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == PC_SEQ) |=> (valid_q && instr_q == $past(fetch_word) && pc1_q == $past(fetch_pc1)));

   a_r7_squash_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == PC_JUMP) |=> !valid_q);

   a_r5_ifid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == PC_HOLD) |=> ($stable(valid_q) && $stable(instr_q) && $stable(pc1_q)));

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
   import fetch_pkg::*;
#(
   parameter int ADDR_W          = 6,
   parameter int DATA_W          = 32,
   parameter int RESET_PC        = 0,
   parameter bit CLEAR_ON_SQUASH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] redirect_target,
   input  logic              load_we,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] ifid_instr,
   output logic [ADDR_W-1:0] ifid_pc1,
   output logic              ifid_valid
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("fetch_unit: ADDR_W must lie in 1..12");
      end
      if (DATA_W < 8 || DATA_W > 128) begin : g_bad_data
         $error("fetch_unit: DATA_W must lie in 8..128");
      end
      if (RESET_PC < 0 || RESET_PC >= DEPTH) begin : g_bad_reset
         $error("fetch_unit: RESET_PC outside the store");
      end
   endgenerate

   pc_sel_e           sel;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_inc;
   logic [DATA_W-1:0] rom_word;

   fetch_ctrl u_ctrl (
      .stall    (stall),
      .redirect (redirect),
      .sel      (sel)
   );

   fetch_pc #(
      .ADDR_W   (ADDR_W),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .target (redirect_target),
      .pc_q   (pc_q),
      .pc_inc (pc_inc)
   );

   fetch_rom #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_rom (
      .clk   (clk),
      .we    (load_we),
      .waddr (load_addr),
      .wdata (load_data),
      .raddr (pc_q),
      .rdata (rom_word)
   );

   fetch_ifid #(
      .ADDR_W          (ADDR_W),
      .DATA_W          (DATA_W),
      .CLEAR_ON_SQUASH (CLEAR_ON_SQUASH)
   ) u_ifid (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .fetch_word (rom_word),
      .fetch_pc1  (pc_inc),
      .instr_q    (ifid_instr),
      .pc1_q      (ifid_pc1),
      .valid_q    (ifid_valid)
   );

   a_r6_redirect_beats_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && stall) |=> (!ifid_valid && pc_q == $past(redirect_target)));

   a_r4_pc1_follows_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !redirect) |=> (ifid_valid && ifid_pc1 == $past(pc_q) + ADDR_W'(1)));

endmodule

// File: tb/fetch_unit_bench.sv
`timescale 1ns/1ps
module fetch_unit_bench;

   localparam int AW    = 6;
   localparam int DW    = 32;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stall = 1'b0;
   logic          redirect = 1'b0;
   logic [AW-1:0] redirect_target = '0;
   logic          load_we = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [DW-1:0] load_data = '0;
   logic [DW-1:0] ifid_instr;
   logic [AW-1:0] ifid_pc1;
   logic          ifid_valid;

   always #2.5 clk = ~clk;

   fetch_unit #(.ADDR_W(AW), .DATA_W(DW)) u_fetch_unit (
      .clk             (clk),
      .rst_n           (rst_n),
      .stall           (stall),
      .redirect        (redirect),
      .redirect_target (redirect_target),
      .load_we         (load_we),
      .load_addr       (load_addr),
      .load_data       (load_data),
      .ifid_instr      (ifid_instr),
      .ifid_pc1        (ifid_pc1),
      .ifid_valid      (ifid_valid)
   );

   // Reference model state
   logic [DW-1:0] mdl_mem [DEPTH];
   logic [AW-1:0] m_pc;
   logic [DW-1:0] e_instr;
   logic [AW-1:0] e_pc1;
   logic          e_valid;

   int  errors = 0;
   int  checks = 0;
   bit  done   = 1'b0;

   task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      check(req, "ifid_valid", DW'(ifid_valid), DW'(e_valid));
      check(req, "ifid_instr", ifid_instr, e_instr);
      check(req, "ifid_pc1", DW'(ifid_pc1), DW'(e_pc1));
   endtask

   // Drive one cycle at the negedge, update the model at the edge, compare at the next negedge
   task automatic step(input string req, input logic st, input logic rd, input logic [AW-1:0] tg,
                       input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd);
      stall = st;
      redirect = rd;
      redirect_target = tg;
      load_we = we;
      load_addr = wa;
      load_data = wd;
      @(posedge clk);
      if (rd) begin
         m_pc = tg;
         e_valid = 1'b0;
         e_instr = '0;
         e_pc1 = '0;
      end else if (!st) begin
         e_instr = mdl_mem[m_pc];
         e_pc1 = m_pc + AW'(1);
         e_valid = 1'b1;
         m_pc = m_pc + AW'(1);
      end
      if (we) mdl_mem[wa] = wd;
      @(negedge clk);
      check_outputs(req);
   endtask

   task automatic run(input string req, input logic st, input logic rd, input logic [AW-1:0] tg);
      step(req, st, rd, tg, 1'b0, '0, '0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      m_pc = '0;
      e_instr = '0;
      e_pc1 = '0;
      e_valid = 1'b0;

      // Fill the store while held in reset (R8 write port)
      @(negedge clk);
      for (int i = 0; i < DEPTH; i++) begin
         load_we = 1'b1;
         load_addr = AW'(i);
         load_data = $urandom();
         mdl_mem[i] = load_data;
         @(negedge clk);
      end
      load_we = 1'b0;

      // R1: reset state
      check_outputs("R1");
      rst_n = 1'b1;

      // R1: first fetch from address 0; R2/R3 sequential run
      run("R1", 1'b0, 1'b0, '0);
      for (int i = 0; i < 5; i++) run("R3", 1'b0, 1'b0, '0);

      // R5: stall holds a valid slot
      for (int i = 0; i < 3; i++) run("R5", 1'b1, 1'b0, AW'(9));
      run("R2", 1'b0, 1'b0, '0);

      // R4: redirect then resume at target
      run("R4", 1'b0, 1'b1, AW'(20));
      run("R4", 1'b0, 1'b0, '0);
      run("R4", 1'b0, 1'b0, '0);

      // R6: redirect together with stall
      run("R6", 1'b1, 1'b1, AW'(40));
      run("R6", 1'b0, 1'b0, '0);

      // R7: back-to-back redirects, then a stalled bubble (R5)
      run("R7", 1'b0, 1'b1, AW'(3));
      run("R7", 1'b0, 1'b1, AW'(50));
      run("R5", 1'b1, 1'b0, '0);
      run("R5", 1'b1, 1'b0, '0);
      run("R4", 1'b0, 1'b0, '0);

      // R2: wrap from the top of the store back to 0
      run("R2", 1'b0, 1'b1, AW'(DEPTH - 2));
      for (int i = 0; i < 4; i++) run("R2", 1'b0, 1'b0, '0);

      // R8: rewrite a word while stalled, then fetch it
      step("R8", 1'b1, 1'b0, '0, 1'b1, AW'(10), 32'hC0DE_5A5A);
      run("R8", 1'b0, 1'b1, AW'(10));
      run("R8", 1'b0, 1'b0, '0);

      // Random mix of stalls and redirects
      for (int i = 0; i < 400; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         run("R3", (r < 25) || (r >= 90), (r >= 80), AW'($urandom()));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule